// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Event Qualifier

This block sits after a bank of instruction-address and data-address comparators. Each comparator reports a raw hit. The block decides whether that hit becomes a debug event. It checks every hit against the control word of its comparator, and against the processor context in the sampled cycle: exception level, security state, whether a data access came from an unprivileged load or store, and the current context identifier. A comparator may also be tied to a context-aware breakpoint. In that case the hit counts only when the linked breakpoint is enabled, is of the context-ID kind, and holds a value equal to the current context identifier.

The surrounding pipeline pulses `sampleStb` when a set of hits is ready. One clock later the block presents a breakpoint event flag, a watchpoint event flag and the index of the first qualifying comparator. Events are held off entirely while monitor debug is disabled or debug exceptions cannot be taken. The block does not compare addresses and does not raise the exception itself.

Top module: `dbg_bpwp_qualifier`

## Requirements
- R1: The security field (control bits [15:14]) sets which security states accept a hit. A value of 0 accepts both states. A value of 1 or 3 rejects the hit in the secure state. A value of 2 rejects it in the non-secure state.
- R2: The privilege check depends on the exception level. At level 2 or 3 the hit needs the higher-mode bit (control bit 13) set. At level 1 it needs control bit 1 set. At level 0 it needs control bit 2 set.
- R3: For a watchpoint only, a hit with `unprivAccess` high is judged as if made at level 0, whatever `excLevel` is.
- R4: When control bit 20 (link enable) is set, the hit counts only if the link number in control bits [19:16] names a context-aware breakpoint. Those are indices NUM_BP-NUM_CTX to NUM_BP-1. Any other link number rejects the hit.
- R5: The linked breakpoint must have its enable bit (control bit 0) set, and its type field (control bits [23:20]) must equal 3. Any other type, reserved values included, rejects the hit.
- R6: A context-ID link fails whenever `excLevel` is above 1. Otherwise it needs all 32 bits of `contextId` to equal the value word of the linked breakpoint.
- R7: No event is reported, and the index reads 0, for any sample taken while `monitorEn` or `debugExcEn` is low.
- R8: Among qualifying comparators the lowest index wins. If any breakpoint qualifies, `hitIdx` gives the breakpoint index. Otherwise it gives the watchpoint index. With no event, `hitIdx` is 0.
- R9: The outputs change only on the clock edge at which `sampleStb` is high, and they hold between strobes. After reset all outputs are 0.
- R10: A comparator whose raw hit bit is low never produces an event, whatever its control word says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | Capture the qualified result at this edge |
| bpHit | input | NUM_BP | Raw address hit per breakpoint |
| wpHit | input | NUM_WP | Raw address hit per watchpoint |
| bpCtrl | input | 32*NUM_BP | Breakpoint control words; entry n occupies bits [32n+31:32n] |
| bpValue | input | 32*NUM_BP | Breakpoint value words used for context matching |
| wpCtrl | input | 32*NUM_WP | Watchpoint control words |
| excLevel | input | 2 | Current exception level, 0 to 3 |
| secureState | input | 1 | 1 when the processor is in the secure state |
| unprivAccess | input | 1 | The data access came from an unprivileged load or store |
| contextId | input | 32 | Current context identifier |
| monitorEn | input | 1 | Global monitor debug enable |
| debugExcEn | input | 1 | Debug exceptions can be taken now |
| bpEvent | output | 1 | A breakpoint qualified at the last strobe |
| wpEvent | output | 1 | A watchpoint qualified at the last strobe |
| hitIdx | output | IDX_W | Index of the reported comparator |

## Verification
A single breakpoint is swept through every combination of security field, privilege bits, higher-mode bit, security state and exception level. This separates the security filter from the privilege filter. The same sweep runs on a watchpoint with the unprivileged flag both high and low, which shows the level-0 override acting on watchpoints only. The link sweep covers every link number, every target type, target enable on and off, all four levels, and matching and non-matching context values. It shows that the range check, the type check and the level check each reject on their own. Full sweeps of the hit masks, the two global enables and a strobe-free stretch then test lowest-index priority, the gating and the holding of the outputs.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;

  localparam int unsigned CTL_W       = 32;
  localparam int unsigned ENA_BIT     = 0;
  localparam int unsigned PRIV_LO     = 1;
  localparam int unsigned HMODE_BIT   = 13;
  localparam int unsigned SEC_LO      = 14;
  localparam int unsigned LNUM_LO     = 16;
  localparam int unsigned LNUM_W      = 4;
  localparam int unsigned LINK_EN_BIT = 20;
  localparam int unsigned TYPE_LO     = 20;
  localparam logic [3:0]  CTXID_TYPE  = 4'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the output registers this edge
    logic armed;    // events may be reported
  } dbgq_strobe_t;

  function automatic logic secPass(input logic [1:0] sel, input logic secure);
    logic ok;
    unique case (sel)
      2'd0:    ok = 1'b1;
      2'd2:    ok = secure;
      default: ok = !secure;
    endcase
    return ok;
  endfunction

  function automatic logic lvlPass(input logic [1:0] lvl, input logic [1:0] priv,
                                   input logic hmode);
    logic ok;
    unique case (lvl)
      2'd0:    ok = priv[1];
      2'd1:    ok = priv[0];
      default: ok = hmode;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/dbgq_link_eval.sv
module dbgq_link_eval
  import dbgq_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_CTX = 2
) (
  input  logic [CTL_W*NUM_BP-1:0] bpCtrl,
  input  logic [CTL_W*NUM_BP-1:0] bpValue,
  input  logic [1:0]              excLevel,
  input  logic [31:0]             contextId,
  output logic [(1<<LNUM_W)-1:0]  linkOk
);

  localparam int NUM_LINK = 1 << LNUM_W;
  localparam int CTX_BASE = NUM_BP - NUM_CTX;

  logic lowLevel;
  assign lowLevel = (excLevel <= 2'd1);

  for (genvar n = 0; n < NUM_LINK; n++) begin : g_link
    if (n >= CTX_BASE && n < NUM_BP) begin : g_ctx
      logic [CTL_W-1:0] tgtCtrl;
      logic [31:0]      tgtValue;
      logic             enaOk;
      logic             typeOk;
      logic             valOk;
      assign tgtCtrl  = bpCtrl[n*CTL_W +: CTL_W];
      assign tgtValue = bpValue[n*CTL_W +: 32];
      assign enaOk    = tgtCtrl[ENA_BIT];
      assign typeOk   = (tgtCtrl[TYPE_LO +: 4] == CTXID_TYPE);
      assign valOk    = (tgtValue == contextId);
      assign linkOk[n] = enaOk && typeOk && lowLevel && valOk;
    end else begin : g_none
      assign linkOk[n] = 1'b0;
    end
  end

endmodule

// File: rtl/dbgq_entry_filter.sv
module dbgq_entry_filter
  import dbgq_pkg::*;
#(
  parameter bit IS_WP = 1'b0
) (
  input  logic                   rawHit,
  input  logic [CTL_W-1:0]       ctrl,
  input  logic [1:0]             excLevel,
  input  logic                   secureState,
  input  logic                   unprivAccess,
  input  logic [(1<<LNUM_W)-1:0] linkOk,
  output logic                   qualified
);

  logic [1:0]        effLevel;
  logic              secOk;
  logic              levelOk;
  logic              linkPass;
  logic [LNUM_W-1:0] linkNum;

  if (IS_WP) begin : g_wp
    assign effLevel = unprivAccess ? 2'd0 : excLevel;
  end else begin : g_bp
    logic unusedUnpriv;
    assign unusedUnpriv = unprivAccess;
    assign effLevel     = excLevel;
  end

  assign linkNum  = ctrl[LNUM_LO +: LNUM_W];
  assign secOk    = secPass(ctrl[SEC_LO +: 2], secureState);
  assign levelOk  = lvlPass(effLevel, ctrl[PRIV_LO +: 2], ctrl[HMODE_BIT]);
  assign linkPass = !ctrl[LINK_EN_BIT] || linkOk[linkNum];

  assign qualified = rawHit && secOk && levelOk && linkPass;

endmodule

// File: rtl/dbgq_control.sv
module dbgq_control
  import dbgq_pkg::*;
(
  input  logic         sampleStb,
  input  logic         monitorEn,
  input  logic         debugExcEn,
  output dbgq_strobe_t strobes
);

  always_comb begin
    strobes.capture = sampleStb;
    strobes.armed   = monitorEn && debugExcEn;
  end

endmodule

// File: rtl/dbgq_datapath.sv
module dbgq_datapath
  import dbgq_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_WP  = 2,
  parameter int NUM_CTX = 2,
  parameter int IDX_W   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dbgq_strobe_t            strobes,
  input  logic [NUM_BP-1:0]       bpHit,
  input  logic [NUM_WP-1:0]       wpHit,
  input  logic [CTL_W*NUM_BP-1:0] bpCtrl,
  input  logic [CTL_W*NUM_BP-1:0] bpValue,
  input  logic [CTL_W*NUM_WP-1:0] wpCtrl,
  input  logic [1:0]              excLevel,
  input  logic                    secureState,
  input  logic                    unprivAccess,
  input  logic [31:0]             contextId,
  output logic                    bpEvent,
  output logic                    wpEvent,
  output logic [IDX_W-1:0]        hitIdx
);

  logic [(1<<LNUM_W)-1:0] linkOk;
  logic [NUM_BP-1:0]      bpQual;
  logic [NUM_WP-1:0]      wpQual;

  dbgq_link_eval #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_link (
    .bpCtrl    (bpCtrl),
    .bpValue   (bpValue),
    .excLevel  (excLevel),
    .contextId (contextId),
    .linkOk    (linkOk)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    dbgq_entry_filter #(.IS_WP(1'b0)) u_filt (
      .rawHit       (bpHit[i]),
      .ctrl         (bpCtrl[i*CTL_W +: CTL_W]),
      .excLevel     (excLevel),
      .secureState  (secureState),
      .unprivAccess (unprivAccess),
      .linkOk       (linkOk),
      .qualified    (bpQual[i])
    );
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    dbgq_entry_filter #(.IS_WP(1'b1)) u_filt (
      .rawHit       (wpHit[i]),
      .ctrl         (wpCtrl[i*CTL_W +: CTL_W]),
      .excLevel     (excLevel),
      .secureState  (secureState),
      .unprivAccess (unprivAccess),
      .linkOk       (linkOk),
      .qualified    (wpQual[i])
    );
  end

  // lowest index wins: scan downward so the last write is the lowest
  logic [IDX_W-1:0] bpIdxC;
  logic [IDX_W-1:0] wpIdxC;
  always_comb begin
    bpIdxC = '0;
    for (int i = NUM_BP - 1; i >= 0; i--) begin
      if (bpQual[i]) bpIdxC = IDX_W'(i);
    end
  end
  always_comb begin
    wpIdxC = '0;
    for (int i = NUM_WP - 1; i >= 0; i--) begin
      if (wpQual[i]) wpIdxC = IDX_W'(i);
    end
  end

  logic             bpAny;
  logic             wpAny;
  logic [IDX_W-1:0] nextIdx;
  assign bpAny   = |bpQual;
  assign wpAny   = |wpQual;
  assign nextIdx = bpAny ? bpIdxC : (wpAny ? wpIdxC : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpEvent <= 1'b0;
      wpEvent <= 1'b0;
      hitIdx  <= '0;
    end else if (strobes.capture) begin
      bpEvent <= strobes.armed && bpAny;
      wpEvent <= strobes.armed && wpAny;
      hitIdx  <= strobes.armed ? nextIdx : '0;
    end
  end

endmodule

// File: rtl/dbg_bpwp_qualifier.sv
module dbg_bpwp_qualifier
  import dbgq_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_WP  = 2,
  parameter int NUM_CTX = 2,
  localparam int MAX_N  = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
  localparam int IDX_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleStb,
  input  logic [NUM_BP-1:0]       bpHit,
  input  logic [NUM_WP-1:0]       wpHit,
  input  logic [32*NUM_BP-1:0]    bpCtrl,
  input  logic [32*NUM_BP-1:0]    bpValue,
  input  logic [32*NUM_WP-1:0]    wpCtrl,
  input  logic [1:0]              excLevel,
  input  logic                    secureState,
  input  logic                    unprivAccess,
  input  logic [31:0]             contextId,
  input  logic                    monitorEn,
  input  logic                    debugExcEn,
  output logic                    bpEvent,
  output logic                    wpEvent,
  output logic [IDX_W-1:0]        hitIdx
);

  dbgq_strobe_t strobes;

  dbgq_control u_ctrl (
    .sampleStb  (sampleStb),
    .monitorEn  (monitorEn),
    .debugExcEn (debugExcEn),
    .strobes    (strobes)
  );

  dbgq_datapath #(
    .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .NUM_CTX(NUM_CTX), .IDX_W(IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .bpHit        (bpHit),
    .wpHit        (wpHit),
    .bpCtrl       (bpCtrl),
    .bpValue      (bpValue),
    .wpCtrl       (wpCtrl),
    .excLevel     (excLevel),
    .secureState  (secureState),
    .unprivAccess (unprivAccess),
    .contextId    (contextId),
    .bpEvent      (bpEvent),
    .wpEvent      (wpEvent),
    .hitIdx       (hitIdx)
  );

endmodule

// File: rtl/dbg_bpwp_qualifier_checker.sv
module dbg_bpwp_qualifier_checker #(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 2,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleStb,
  input logic [NUM_BP-1:0] bpHit,
  input logic [NUM_WP-1:0] wpHit,
  input logic              monitorEn,
  input logic              debugExcEn,
  input logic              bpEvent,
  input logic              wpEvent,
  input logic [IDX_W-1:0]  hitIdx
);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb && !(monitorEn && debugExcEn) |=> !bpEvent && !wpEvent && hitIdx == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> $stable(bpEvent) && $stable(wpEvent) && $stable(hitIdx));

  p_nobp_r10: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb && bpHit == '0 |=> !bpEvent);

  p_nowp_r10: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb && wpHit == '0 |=> !wpEvent);

  p_bpidx_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !bpEvent || ((($past(bpHit) >> hitIdx) & NUM_BP'(1)) != '0));

  p_wpidx_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> bpEvent || !wpEvent || ((($past(wpHit) >> hitIdx) & NUM_WP'(1)) != '0));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !bpEvent && !wpEvent |-> hitIdx == '0);

endmodule

bind dbg_bpwp_qualifier dbg_bpwp_qualifier_checker #(
  .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .IDX_W(IDX_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .sampleStb  (sampleStb),
  .bpHit      (bpHit),
  .wpHit      (wpHit),
  .monitorEn  (monitorEn),
  .debugExcEn (debugExcEn),
  .bpEvent    (bpEvent),
  .wpEvent    (wpEvent),
  .hitIdx     (hitIdx)
);

// File: tb/dbg_bpwp_qualifier_test.sv
module dbg_bpwp_qualifier_test;

  localparam int NB = 4;
  localparam int NW = 2;
  localparam int NC = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleStb = 1'b0;
  logic [NB-1:0]     bpHit = '0;
  logic [NW-1:0]     wpHit = '0;
  logic [32*NB-1:0]  bpCtrl = '0;
  logic [32*NB-1:0]  bpValue = '0;
  logic [32*NW-1:0]  wpCtrl = '0;
  logic [1:0]        excLevel = '0;
  logic              secureState = 1'b0;
  logic              unprivAccess = 1'b0;
  logic [31:0]       contextId = '0;
  logic              monitorEn = 1'b1;
  logic              debugExcEn = 1'b1;
  logic              bpEvent;
  logic              wpEvent;
  logic [1:0]        hitIdx;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dbg_bpwp_qualifier #(.NUM_BP(NB), .NUM_WP(NW), .NUM_CTX(NC)) uut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .bpHit(bpHit), .wpHit(wpHit),
    .bpCtrl(bpCtrl), .bpValue(bpValue), .wpCtrl(wpCtrl), .excLevel(excLevel),
    .secureState(secureState), .unprivAccess(unprivAccess), .contextId(contextId),
    .monitorEn(monitorEn), .debugExcEn(debugExcEn),
    .bpEvent(bpEvent), .wpEvent(wpEvent), .hitIdx(hitIdx)
  );

  // control word that accepts every level and both security states
  localparam logic [31:0] OPEN = 32'h0000_2006;

  function automatic bit linkGood(input logic [31:0] c);
    int n;
    logic [31:0] t;
    if (!c[20]) return 1'b1;
    n = int'(c[19:16]);
    if (n < NB - NC || n > NB - 1) return 1'b0;
    t = bpCtrl[n*32 +: 32];
    if (!t[0] || t[23:20] != 4'd3) return 1'b0;
    if (excLevel > 2'd1) return 1'b0;
    return contextId == bpValue[n*32 +: 32];
  endfunction

  function automatic bit entryGood(input logic [31:0] c, input bit isWp);
    int lvl;
    bit secOk;
    bit lvlOk;
    secOk = (c[15:14] == 2'd0) || (c[15:14] == 2'd2 && secureState) ||
            ((c[15:14] == 2'd1 || c[15:14] == 2'd3) && !secureState);
    lvl = (isWp && unprivAccess) ? 0 : int'(excLevel);
    lvlOk = (lvl >= 2) ? c[13] : (lvl == 1) ? c[1] : c[2];
    return secOk && lvlOk && linkGood(c);
  endfunction

  task automatic compare(input string req, input bit eb, input bit ew, input int ei);
    vectors++;
    if (bpEvent !== eb || wpEvent !== ew || int'(hitIdx) != ei) begin
      miscompares++;
      $display("FAIL %s: got bp=%0b wp=%0b idx=%0d, expected bp=%0b wp=%0b idx=%0d",
               req, bpEvent, wpEvent, hitIdx, eb, ew, ei);
    end
  endtask

  // strobe the current inputs and compare against the model one edge later
  task automatic apply(input string req);
    bit eb;
    bit ew;
    int ei;
    int bi;
    int wi;
    eb = 0; ew = 0; bi = -1; wi = -1;
    for (int i = 0; i < NB; i++)
      if (bpHit[i] && entryGood(bpCtrl[i*32 +: 32], 1'b0) && bi < 0) bi = i;
    for (int i = 0; i < NW; i++)
      if (wpHit[i] && entryGood(wpCtrl[i*32 +: 32], 1'b1) && wi < 0) wi = i;
    if (monitorEn && debugExcEn) begin
      eb = (bi >= 0);
      ew = (wi >= 0);
    end
    ei = eb ? bi : (ew ? wi : 0);
    @(negedge clk);
    sampleStb = 1'b1;
    @(posedge clk);
    #1;
    sampleStb = 1'b0;
    compare(req, eb, ew, ei);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R9 reset", 1'b0, 1'b0, 0);
    rstN = 1'b1;

    // R1 R2: one breakpoint, full field sweep
    bpHit = 4'b0001;
    for (int f = 0; f < 32; f++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 4; l++) begin
          bpCtrl[31:0] = 32'((f & 3) << 14) | 32'(((f >> 2) & 3) << 1) | 32'(((f >> 4) & 1) << 13);
          secureState = s[0];
          excLevel = l[1:0];
          apply("R1/R2 bp field sweep");
        end
    bpHit = '0;
    bpCtrl = '0;

    // R3: watchpoint sweep, unprivileged flag both ways
    wpHit = 2'b10;
    for (int f = 0; f < 32; f++)
      for (int u = 0; u < 2; u++)
        for (int l = 0; l < 4; l++) begin
          wpCtrl[63:32] = 32'((f & 3) << 14) | 32'(((f >> 2) & 3) << 1) | 32'(((f >> 4) & 1) << 13);
          unprivAccess = u[0];
          excLevel = l[1:0];
          secureState = f[0];
          apply("R3 wp unpriv sweep");
        end
    // R3: unprivileged flag must not alter a breakpoint's level
    wpHit = '0;
    bpHit = 4'b0001;
    bpCtrl[31:0] = 32'h0000_0004;
    excLevel = 2'd1;
    unprivAccess = 1'b1;
    apply("R3 bp unaffected");
    unprivAccess = 1'b0;

    // R4 R5 R6: link sweep on breakpoint 0
    bpValue = {32'hCAFE_0003, 32'hCAFE_0002, 32'hCAFE_0001, 32'hCAFE_0000};
    for (int n = 0; n < 16; n++)
      for (int e = 0; e < 2; e++)
        for (int t = 0; t < 16; t++)
          for (int l = 0; l < 4; l++)
            for (int m = 0; m < 2; m++) begin
              bpCtrl[31:0] = OPEN | 32'h0010_0000 | 32'(n << 16);
              for (int k = 1; k < NB; k++) bpCtrl[k*32 +: 32] = 32'(t << 20) | 32'(e);
              excLevel = l[1:0];
              contextId = (n < NB) ? (bpValue[n*32 +: 32] ^ 32'(m == 0)) : 32'hCAFE_0003;
              apply("R4/R5/R6 link sweep");
            end
    // R6: a single-bit difference in the top bit of the context rejects
    bpCtrl[31:0] = OPEN | 32'h0013_0000;
    bpCtrl[127:96] = 32'h0030_0001;
    excLevel = 2'd1;
    contextId = 32'h4AFE_0003;
    apply("R6 top bit differs");
    contextId = 32'hCAFE_0003;
    apply("R6 exact match");
    bpCtrl = '0;
    bpValue = '0;
    contextId = '0;

    // R8 R10: every hit mask with open controls
    for (int i = 0; i < NB; i++) bpCtrl[i*32 +: 32] = OPEN;
    for (int i = 0; i < NW; i++) wpCtrl[i*32 +: 32] = OPEN;
    excLevel = 2'd0;
    for (int b = 0; b < 16; b++)
      for (int w = 0; w < 4; w++) begin
        bpHit = b[3:0];
        wpHit = w[1:0];
        apply("R8/R10 priority sweep");
      end
    // R10: qualifying controls on entries whose raw hit is low
    bpHit = 4'b0000;
    wpHit = 2'b00;
    apply("R10 no raw hit");

    // R7: global gating
    bpHit = 4'b0110;
    wpHit = 2'b11;
    for (int g = 0; g < 4; g++) begin
      monitorEn = g[0];
      debugExcEn = g[1];
      apply("R7 gating");
    end

    // R9: no strobe, outputs hold
    monitorEn = 1'b1;
    debugExcEn = 1'b1;
    bpHit = 4'b1000;
    wpHit = 2'b00;
    apply("R9 load");
    bpHit = 4'b0000;
    wpHit = 2'b01;
    repeat (4) @(negedge clk);
    compare("R9 hold", 1'b1, 1'b0, 3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule